// File: doc/BRIEF.md
# Global power-down sequencer

This block drives chip-wide power-down from the memory-interface side. Power-down begins when software writes to a memory-mapped register that holds no data. The write itself is the trigger. The block first lets any SDRAM transfer still in progress finish. It then asks the SDRAM controller to enter self-refresh. Once the controller acknowledges, the block raises a global power-down level, and every participating unit gates its own clock in response.

The block then waits for a wake event. A wake event is either an interrupt or a memory request from a unit that stays clocked. On wake, the block drops the global level first. It then asks the controller to leave self-refresh. Only after that does it complete the register write that started the sequence. The write is therefore held stalled for the whole sleep.

A memory request from a unit that stays clocked is held off for as long as SDRAM is, or is about to be, in self-refresh. The request is granted once the block is back in service.

Top module: `pdn_sequencer`

## Requirements
- R1: A write (`cfg_req`=1, `cfg_we`=1) whose `cfg_addr` equals `PD_ADDR` (default 0x100108) starts the sequence while the block is idle. A write to any other address has no effect on `sr_req`, `global_pd` or `wr_done`.
- R2: A read of `PD_ADDR` returns `rd_ack`=1 in the cycle after the request, with `rdata` all zeros. The read does not start the sequence.
- R3: `sr_req` does not rise while `mem_busy` is high. The block waits until the in-flight transfer has ended.
- R4: `global_pd` is high only while `sr_req` and `sr_ack` are both high. It rises in the cycle after `sr_ack` is first seen high.
- R5: While asleep, a high `irq` or a high `ext_req` sampled at a clock edge drops `global_pd` in the following cycle.
- R6: On exit, `global_pd` falls together with `sr_req`. `wr_done` follows only after `sr_ack` has been seen low.
- R7: `wr_done` is a single-cycle pulse. The block is idle in the cycle after it.
- R8: A wake event seen while draining or entering self-refresh is remembered. `global_pd` is then high for exactly one cycle before the exit begins.
- R9: `ext_gnt` equals `ext_req` while the block is idle or completing the write. It is 0 from the start of draining until self-refresh exit has finished.
- R10: During reset and right after it, `global_pd`, `sr_req`, `wr_done`, `rd_ack` and `ext_gnt` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also the SDRAM-side clock, which keeps running |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_req | input | 1 | Register access request |
| cfg_we | input | 1 | 1 = write, 0 = read |
| cfg_addr | input | ADDR_W | Register offset |
| rdata | output | DATA_W | Read data, always zero |
| rd_ack | output | 1 | Read completion pulse |
| wr_done | output | 1 | Completion pulse of the trigger write |
| mem_busy | input | 1 | An SDRAM transfer is in flight |
| sr_req | output | 1 | Self-refresh request to the SDRAM controller |
| sr_ack | input | 1 | SDRAM is in self-refresh |
| global_pd | output | 1 | Global power-down level to participating units |
| irq | input | 1 | Interrupt seen by the interrupt controller |
| ext_req | input | 1 | Memory request from a unit that stays clocked |
| ext_gnt | output | 1 | Grant for `ext_req` |

## Verification
The hardest case to reach from the ports is a wake event that arrives before sleep has begun. This is the latched path, in which the sleep lasts a single cycle. To reach it, the stimulus holds `mem_busy` high across the trigger write and pulses `irq` while the block is still draining. A second run raises `ext_req` in the very cycle `sr_req` appears, while the slow self-refresh acknowledge keeps the block in its entry phase. A behavioural model in the bench tracks each phase and checks every output on every cycle. Explicit checks confirm that the sleep window was exactly one cycle long.

// File: rtl/pdn_pkg.sv
package pdn_pkg;
  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_DRAIN    = 3'd1,
    ST_SR_ENTER = 3'd2,
    ST_SLEEP    = 3'd3,
    ST_SR_EXIT  = 3'd4,
    ST_ACK      = 3'd5
  } pdn_state_e;
endpackage

// File: rtl/pdn_rst_sync.sv
module pdn_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/pdn_reg_decode.sv
module pdn_reg_decode #(
  parameter int              ADDR_W  = 24,
  parameter int              DATA_W  = 32,
  parameter logic [ADDR_W-1:0] PD_ADDR = 24'h100108
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_req,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  output logic              trig,
  output logic              rd_ack,
  output logic [DATA_W-1:0] rdata
);
  logic hit;
  logic rd_hit;
  logic rd_ack_q;

  assign hit    = cfg_req && (cfg_addr == PD_ADDR);
  assign trig   = hit && cfg_we;
  assign rd_hit = hit && !cfg_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_ack_q <= 1'b0;
    else        rd_ack_q <= rd_hit;
  end

  assign rd_ack = rd_ack_q;
  assign rdata  = '0;
endmodule

// File: rtl/pdn_wake_latch.sv
module pdn_wake_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic clr,
  input  logic wake_in,
  output logic pend
);
  logic pend_q;
  logic pend_d;
  logic pend_en;

  always_comb begin
    pend_en = clr || (arm && wake_in);
    pend_d  = clr ? 1'b0 : 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= 1'b0;
    else if (pend_en) pend_q <= pend_d;
  end

  assign pend = pend_q;
endmodule

// File: rtl/pdn_fsm.sv
module pdn_fsm
  import pdn_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  input  logic mem_busy,
  input  logic sr_ack,
  input  logic wake_now,
  input  logic wake_pend,
  output logic sr_req,
  output logic global_pd,
  output logic wr_done,
  output logic early_arm,
  output logic pend_clr,
  output logic grant_ok
);
  pdn_state_e state_q;
  pdn_state_e state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:     if (trig)                   state_d = ST_DRAIN;
      ST_DRAIN:    if (!mem_busy)              state_d = ST_SR_ENTER;
      ST_SR_ENTER: if (sr_ack)                 state_d = ST_SLEEP;
      ST_SLEEP:    if (wake_now || wake_pend)  state_d = ST_SR_EXIT;
      ST_SR_EXIT:  if (!sr_ack)                state_d = ST_ACK;
      ST_ACK:                                  state_d = ST_IDLE;
      default:                                 state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_comb begin
    sr_req    = (state_q == ST_SR_ENTER) || (state_q == ST_SLEEP);
    global_pd = (state_q == ST_SLEEP);
    wr_done   = (state_q == ST_ACK);
    early_arm = (state_q == ST_DRAIN) || (state_q == ST_SR_ENTER);
    pend_clr  = (state_q == ST_SLEEP) && (state_d == ST_SR_EXIT);
    grant_ok  = (state_q == ST_IDLE) || (state_q == ST_ACK);
  end
endmodule

// File: rtl/pdn_sequencer.sv
module pdn_sequencer #(
  parameter int                ADDR_W  = 24,
  parameter int                DATA_W  = 32,
  parameter logic [ADDR_W-1:0] PD_ADDR = 24'h100108,
  parameter int                RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_req,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  output logic [DATA_W-1:0] rdata,
  output logic              rd_ack,
  output logic              wr_done,
  input  logic              mem_busy,
  output logic              sr_req,
  input  logic              sr_ack,
  output logic              global_pd,
  input  logic              irq,
  input  logic              ext_req,
  output logic              ext_gnt
);
  logic rst_n_i;
  logic trig;
  logic wake_now;
  logic wake_pend;
  logic early_arm;
  logic pend_clr;
  logic grant_ok;

  pdn_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  pdn_reg_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PD_ADDR(PD_ADDR)) u_dec (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .cfg_req  (cfg_req),
    .cfg_we   (cfg_we),
    .cfg_addr (cfg_addr),
    .trig     (trig),
    .rd_ack   (rd_ack),
    .rdata    (rdata)
  );

  assign wake_now = irq || ext_req;

  pdn_wake_latch u_wake (
    .clk     (clk),
    .rst_n   (rst_n_i),
    .arm     (early_arm),
    .clr     (pend_clr),
    .wake_in (wake_now),
    .pend    (wake_pend)
  );

  pdn_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .trig      (trig),
    .mem_busy  (mem_busy),
    .sr_ack    (sr_ack),
    .wake_now  (wake_now),
    .wake_pend (wake_pend),
    .sr_req    (sr_req),
    .global_pd (global_pd),
    .wr_done   (wr_done),
    .early_arm (early_arm),
    .pend_clr  (pend_clr),
    .grant_ok  (grant_ok)
  );

  assign ext_gnt = ext_req && grant_ok;
endmodule

// File: rtl/pdn_sequencer_chk.sv
module pdn_sequencer_chk #(
  parameter int                ADDR_W  = 24,
  parameter logic [ADDR_W-1:0] PD_ADDR = 24'h100108
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_req,
  input logic              cfg_we,
  input logic [ADDR_W-1:0] cfg_addr,
  input logic              mem_busy,
  input logic              sr_ack,
  input logic              ext_req,
  input logic              global_pd,
  input logic              sr_req,
  input logic              wr_done,
  input logic              rd_ack,
  input logic              ext_gnt
);
  p_pd_needs_sr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    global_pd |-> (sr_req && sr_ack));

  p_sr_waits_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sr_req) |-> !$past(mem_busy));

  p_exit_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sr_req) |-> !global_pd);

  p_done_after_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done |-> (!sr_req && !global_pd));

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done |=> !wr_done);

  p_no_gnt_asleep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sr_req |-> !ext_gnt);

  p_gnt_has_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ext_gnt |-> ext_req);

  p_rd_ack_source_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ack |-> $past(cfg_req && !cfg_we && (cfg_addr == PD_ADDR)));
endmodule

bind pdn_sequencer pdn_sequencer_chk #(.ADDR_W(ADDR_W), .PD_ADDR(PD_ADDR)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_req   (cfg_req),
  .cfg_we    (cfg_we),
  .cfg_addr  (cfg_addr),
  .mem_busy  (mem_busy),
  .sr_ack    (sr_ack),
  .ext_req   (ext_req),
  .global_pd (global_pd),
  .sr_req    (sr_req),
  .wr_done   (wr_done),
  .rd_ack    (rd_ack),
  .ext_gnt   (ext_gnt)
);

// File: tb/pdn_sequencer_tb.sv
`timescale 1ns/1ps
module pdn_sequencer_tb;
  localparam int          ADDR_W = 24;
  localparam int          DATA_W = 32;
  localparam logic [23:0] PD     = 24'h100108;
  localparam logic [23:0] OTHER  = 24'h100104;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cfg_req = 1'b0, cfg_we = 1'b0;
  logic [ADDR_W-1:0] cfg_addr = '0;
  logic [DATA_W-1:0] rdata;
  logic              rd_ack, wr_done, sr_req, global_pd, ext_gnt;
  logic              mem_busy = 1'b0, irq = 1'b0, ext_req = 1'b0;
  logic              sr_ack;
  logic [1:0]        ack_d;

  int n_chk = 0;
  int n_fail = 0;
  int gpd_cnt = 0;
  bit done_flag = 0;

  always #4 clk = ~clk;

  pdn_sequencer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PD_ADDR(PD)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_req(cfg_req), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .rdata(rdata), .rd_ack(rd_ack), .wr_done(wr_done), .mem_busy(mem_busy),
    .sr_req(sr_req), .sr_ack(sr_ack), .global_pd(global_pd), .irq(irq),
    .ext_req(ext_req), .ext_gnt(ext_gnt)
  );

  // SDRAM controller stand-in: ack follows request two cycles later
  always @(posedge clk or negedge rst_n)
    if (!rst_n) ack_d <= 2'b00;
    else        ack_d <= {ack_d[0], sr_req};
  assign sr_ack = ack_d[1];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference: phase 0 idle, 1 drain, 2 entering, 3 asleep, 4 leaving, 5 completing
  int  ph = 0;
  bit  early = 0;
  bit  exp_rd = 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= 0; early <= 0; exp_rd <= 0;
    end else begin
      exp_rd <= cfg_req && !cfg_we && cfg_addr == PD;
      if ((ph == 1 || ph == 2) && (irq || ext_req)) early <= 1;
      case (ph)
        0: if (cfg_req && cfg_we && cfg_addr == PD) ph <= 1;
        1: if (!mem_busy) ph <= 2;
        2: if (sr_ack) ph <= 3;
        3: if (early || irq || ext_req) begin ph <= 4; early <= 0; end
        4: if (!sr_ack) ph <= 5;
        default: ph <= 0;
      endcase
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      check(global_pd == (ph == 3), "R4 global_pd", global_pd, ph == 3);
      check(sr_req == (ph == 2 || ph == 3), "R3 sr_req", sr_req, ph == 2 || ph == 3);
      check(wr_done == (ph == 5), "R6 wr_done", wr_done, ph == 5);
      check(rd_ack == exp_rd, "R2 rd_ack", rd_ack, exp_rd);
      check(rdata == '0, "R2 rdata", rdata, 0);
      check(ext_gnt == (ext_req && (ph == 0 || ph == 5)), "R9 ext_gnt", ext_gnt,
            ext_req && (ph == 0 || ph == 5));
      if (global_pd) gpd_cnt++;
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  task automatic begin_write(input logic [23:0] a);
    cfg_req = 1; cfg_we = 1; cfg_addr = a; done_flag = 0;
  endtask

  task automatic wait_done();
    while (!wr_done) step(1);
    check(!sr_ack && !global_pd, "R6 done after exit", sr_ack, 0);
    cfg_req = 0; cfg_we = 0;
    step(1);
    check(!wr_done, "R7 done single cycle", wr_done, 0);
    check(!sr_req && !global_pd, "R7 idle after done", sr_req, 0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1;
    check(!global_pd && !sr_req && !wr_done && !rd_ack && !ext_gnt, "R10 reset outputs", global_pd, 0);
    step(3);
    rst_n = 1;
    step(4);
    check(!global_pd && !sr_req && !wr_done && !rd_ack && !ext_gnt, "R10 after release", sr_req, 0);

    // R2 read
    cfg_req = 1; cfg_we = 0; cfg_addr = PD; step(1);
    cfg_req = 0;
    check(rd_ack == 1 && rdata == 0, "R2 read response", rd_ack, 1);
    step(6);
    check(!sr_req, "R2 read no trigger", sr_req, 0);

    // R1 other address ignored
    cfg_req = 1; cfg_we = 1; cfg_addr = OTHER; step(1);
    cfg_req = 0; cfg_we = 0;
    step(8);
    check(!sr_req && !global_pd && !wr_done, "R1 other addr ignored", sr_req, 0);

    // R1/R3/R5 normal sequence with drain and irq wake
    mem_busy = 1;
    begin_write(PD); step(1);
    step(4);
    check(!sr_req, "R3 waits for busy", sr_req, 0);
    ext_req = 1; step(1);
    check(!ext_gnt, "R9 held off while draining", ext_gnt, 0);
    ext_req = 0;
    mem_busy = 0;
    step(1);
    check(sr_req == 1, "R1 sequence started", sr_req, 1);
    // early ext request above was latched; drop latch by finishing this run
    wait_done();

    // normal sleep, irq wake
    gpd_cnt = 0;
    begin_write(PD);
    step(8);
    check(global_pd == 1, "R4 asleep", global_pd, 1);
    step(5);
    irq = 1; step(1); irq = 0;
    check(!global_pd, "R5 irq wakes", global_pd, 1'b0);
    wait_done();
    check(gpd_cnt > 1, "R5 slept several cycles", gpd_cnt, 6);

    // ext request wake, granted afterwards
    begin_write(PD);
    step(10);
    ext_req = 1; step(1);
    check(!global_pd && !ext_gnt, "R5 ext wakes, no grant yet", ext_gnt, 0);
    while (!ext_gnt) step(1);
    check(wr_done || !sr_req, "R9 grant after exit", sr_req, 0);
    ext_req = 0;
    wait_done();

    // R8 early irq during drain
    gpd_cnt = 0;
    mem_busy = 1;
    begin_write(PD); step(2);
    irq = 1; step(1); irq = 0;
    step(2); mem_busy = 0;
    wait_done();
    check(gpd_cnt == 1, "R8 early irq one sleep cycle", gpd_cnt, 1);

    // R8 early ext request during self-refresh entry
    gpd_cnt = 0;
    begin_write(PD);
    while (!sr_req) step(1);
    ext_req = 1;
    while (!ext_gnt) step(1);
    ext_req = 0;
    check(gpd_cnt == 1, "R8 early ext one sleep cycle", gpd_cnt, 1);
    wait_done();

    step(5);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule